// File: doc/BRIEF.md
# Audio Sample Queue Pair with Threshold Requests

This block sits between a simple register-style host port and an audio serializer. It holds two queues of 16-bit samples, each up to 32 entries deep. One queue carries samples from the host toward the serializer (transmit). The other carries captured samples from the serializer back to the host (receive). Samples travel in the upper half of a 32-bit host data word. The lower half is zero on reads and ignored on writes.

The host programs two 5-bit levels. A sticky transmit request flag rises when the transmit queue has drained to its level or below. A sticky receive request flag rises when the receive queue holds more than its level. Each flag drives an interrupt output through its own enable bit. The host clears a flag by writing zero to it. Each queue has its own hold bit, which keeps that queue empty while set, and both hold bits are set out of reset. A self-clearing port-reset bit returns every queue and register to its reset value. Two error flags record a host write into a full transmit queue and a host read from an empty receive queue.

The host reaches four registers through a 2-bit address. Address 0 is control, 1 is status, 2 is levels and 3 is sample data. Read data is combinational, so it is valid in the same cycle as the read strobe.

Top module: `audio_sample_fifo`

## Requirements
- R1: Each queue holds at most 32 samples. The status register (address 1) shows the transmit count in bits 29:24 and the receive count in bits 13:8. Neither count ever exceeds 32.
- R2: A host write to address 3 appends bits 31:16 to the transmit queue. `txSample` shows the oldest transmit sample, and `txAvail` is high when the queue is not empty. A `txTake` pulse removes that sample, so samples leave in the order they were written.
- R3: An `rxPut` pulse appends `rxSample` to the receive queue. A host read of address 3 returns the oldest receive sample in bits 31:16 with bits 15:0 zero, and removes that sample.
- R4: The transmit request flag (status bit 16) sets in the cycle after the transmit queue is released and its count is at or below the transmit level. The transmit level is levels bits 4:0, reset value 15. The flag stays set until the host writes 0 to bit 16 of the status register. Writing 1 to that bit leaves the flag unchanged.
- R5: The receive request flag (status bit 0) sets in the cycle after the receive queue is released and its count is greater than the receive level. The receive level is levels bits 12:8, reset value 0, so a level of 0 fires on one sample. The flag stays set until the host writes 0 to status bit 0.
- R6: `txReqIrq` is the transmit request flag gated by control bit 2. `rxReqIrq` is the receive request flag gated by control bit 3. Both enable bits reset to 0.
- R7: Control bit 0 holds the transmit queue and control bit 1 holds the receive queue. While its hold bit is set, a queue is empty, ignores pushes, and cannot raise its request flag. Both hold bits reset to 1.
- R8: A host write to address 3 while the transmit queue holds 32 samples drops that sample and sets the overrun flag (status bit 20). The host clears the flag by writing 0 to bit 20. Writing 1 to bit 20 leaves it set.
- R9: A host read of address 3 while the receive queue is empty returns 0 and sets the underrun flag (status bit 4). The host clears the flag by writing 0 to bit 4.
- R10: Writing control with bit 8 set returns every register, flag and queue to its reset value at that clock edge. Bit 8 always reads as 0.
- R11: After reset, control reads 0x3, levels reads 0x0000000F, status reads 0, both interrupt outputs are low and `txAvail` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | 2 | Register select: 0 control, 1 status, 2 levels, 3 data |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe (pops the receive queue at address 3) |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data, combinational from hostAddr |
| txTake | input | 1 | Serializer removes the oldest transmit sample |
| txSample | output | 16 | Oldest transmit sample |
| txAvail | output | 1 | Transmit queue is not empty |
| rxPut | input | 1 | Serializer appends a receive sample |
| rxSample | input | 16 | Receive sample from the serializer |
| txReqIrq | output | 1 | Transmit request interrupt |
| rxReqIrq | output | 1 | Receive request interrupt |

## Verification
The bench builds the block with its default parameters: 32-entry queues, 16-bit samples and a 32-bit host word. With a depth this small, the full transmit queue and the dropped 33rd write are reached in a few dozen cycles. The default transmit level of 15 lets the bench watch the request flag return as the serializer drains the queue from 20 entries through the threshold. A receive level of 3, set at run time, separates "count equals level" from "count exceeds level". Reloading the level to 0 after a port reset covers the single-sample case.

// File: rtl/asf_pkg.sv
package asf_pkg;

  // Host register selects; values are the host address
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_STAT  = 2'd1,
    REG_LEVEL = 2'd2,
    REG_DATA  = 2'd3
  } regSel_e;

  // Control bit positions
  localparam int CTRL_TXHOLD  = 0;
  localparam int CTRL_RXHOLD  = 1;
  localparam int CTRL_TXIEN   = 2;
  localparam int CTRL_RXIEN   = 3;
  localparam int CTRL_PORTRST = 8;

  // Status bit positions (decoded by host software)
  localparam int STAT_TXCNT_LSB = 24;
  localparam int STAT_TXOVR     = 20;
  localparam int STAT_TXREQ     = 16;
  localparam int STAT_RXCNT_LSB = 8;
  localparam int STAT_RXUND     = 4;
  localparam int STAT_RXREQ     = 0;

  // Level register field positions
  localparam int LVL_TX_LSB = 0;
  localparam int LVL_RX_LSB = 8;

  // Strobes from control to datapath
  typedef struct packed {
    logic txPush;
    logic txPop;
    logic txClear;
    logic rxPush;
    logic rxPop;
    logic rxClear;
  } qStrobe_t;

  // Control state made visible to the top for the checker
  typedef struct packed {
    logic txHold;
    logic rxHold;
    logic txReqFlag;
    logic rxReqFlag;
    logic txOverrun;
    logic rxUnderrun;
  } ctrlView_t;

endpackage

// File: rtl/asf_queue.sv
module asf_queue #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_C = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic             doPush;
  logic             doPop;

  assign doPush = push && (count != FULL_C) && !clear;
  assign doPop  = pop && (count != '0) && !clear;
  assign headData = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST_C) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST_C) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

endmodule

// File: rtl/asf_datapath.sv
module asf_datapath
  import asf_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int SAMPLE_W = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  qStrobe_t            strobe,
  input  logic [SAMPLE_W-1:0] txPushData,
  input  logic [SAMPLE_W-1:0] rxPushData,
  output logic [SAMPLE_W-1:0] txHead,
  output logic [SAMPLE_W-1:0] rxHead,
  output logic [CNT_W-1:0]    txCount,
  output logic [CNT_W-1:0]    rxCount
);

  asf_queue #(.DEPTH(DEPTH), .WIDTH(SAMPLE_W)) txQueue_i (
    .clk      (clk),
    .rstN     (rstN),
    .clear    (strobe.txClear),
    .push     (strobe.txPush),
    .pushData (txPushData),
    .pop      (strobe.txPop),
    .headData (txHead),
    .count    (txCount)
  );

  asf_queue #(.DEPTH(DEPTH), .WIDTH(SAMPLE_W)) rxQueue_i (
    .clk      (clk),
    .rstN     (rstN),
    .clear    (strobe.rxClear),
    .push     (strobe.rxPush),
    .pushData (rxPushData),
    .pop      (strobe.rxPop),
    .headData (rxHead),
    .count    (rxCount)
  );

endmodule

// File: rtl/asf_ctrl.sv
module asf_ctrl
  import asf_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int SAMPLE_W = 16,
  parameter int WORD_W   = 32,
  localparam int LVL_W = $clog2(DEPTH),
  localparam int CNT_W = LVL_W + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          hostAddr,
  input  logic                hostWr,
  input  logic                hostRd,
  input  logic [WORD_W-1:0]   hostWdata,
  output logic [WORD_W-1:0]   hostRdata,
  input  logic                txTake,
  input  logic                rxPut,
  input  logic [CNT_W-1:0]    txCount,
  input  logic [CNT_W-1:0]    rxCount,
  input  logic [SAMPLE_W-1:0] rxHead,
  output qStrobe_t            strobe,
  output logic                txReqIrq,
  output logic                rxReqIrq,
  output ctrlView_t           view,
  output logic [LVL_W-1:0]    txLevel,
  output logic [LVL_W-1:0]    rxLevel
);

  localparam logic [CNT_W-1:0] FULL_C    = CNT_W'(DEPTH);
  localparam logic [LVL_W-1:0] TXLVL_RST = LVL_W'(DEPTH / 2 - 1);

  regSel_e sel;
  logic wrCtrl, wrStat, wrLevel, wrData, rdData, portClear;
  logic txHold, rxHold, txIrqEn, rxIrqEn;
  logic txReqFlag, rxReqFlag, txOverrun, rxUnderrun;
  logic txSet, rxSet, ovrSet, undSet;
  logic keepTxReq, keepRxReq, keepOvr, keepUnd;
  logic rxEmpty;
  logic unusedWdata;

  assign sel       = regSel_e'(hostAddr);
  assign wrCtrl    = hostWr && (sel == REG_CTRL);
  assign wrStat    = hostWr && (sel == REG_STAT);
  assign wrLevel   = hostWr && (sel == REG_LEVEL);
  assign wrData    = hostWr && (sel == REG_DATA);
  assign rdData    = hostRd && (sel == REG_DATA);
  assign portClear = wrCtrl && hostWdata[CTRL_PORTRST];
  assign rxEmpty   = (rxCount == '0);
  assign unusedWdata = ^hostWdata;

  // Strobes toward the queues
  always_comb begin
    strobe         = '0;
    strobe.txPush  = wrData && !txHold;
    strobe.txPop   = txTake;
    strobe.txClear = txHold || portClear;
    strobe.rxPush  = rxPut && !rxHold;
    strobe.rxPop   = rdData;
    strobe.rxClear = rxHold || portClear;
  end

  // Flag set conditions (threshold and error events)
  assign txSet  = !txHold && (txCount <= {1'b0, txLevel});
  assign rxSet  = !rxHold && (rxCount > {1'b0, rxLevel});
  assign ovrSet = wrData && !txHold && (txCount == FULL_C);
  assign undSet = rdData && rxEmpty;

  // Write-zero-to-clear on status
  assign keepTxReq = !(wrStat && !hostWdata[STAT_TXREQ]);
  assign keepRxReq = !(wrStat && !hostWdata[STAT_RXREQ]);
  assign keepOvr   = !(wrStat && !hostWdata[STAT_TXOVR]);
  assign keepUnd   = !(wrStat && !hostWdata[STAT_RXUND]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold     <= 1'b1;
      rxHold     <= 1'b1;
      txIrqEn    <= 1'b0;
      rxIrqEn    <= 1'b0;
      txLevel    <= TXLVL_RST;
      rxLevel    <= '0;
      txReqFlag  <= 1'b0;
      rxReqFlag  <= 1'b0;
      txOverrun  <= 1'b0;
      rxUnderrun <= 1'b0;
    end else if (portClear) begin
      txHold     <= 1'b1;
      rxHold     <= 1'b1;
      txIrqEn    <= 1'b0;
      rxIrqEn    <= 1'b0;
      txLevel    <= TXLVL_RST;
      rxLevel    <= '0;
      txReqFlag  <= 1'b0;
      rxReqFlag  <= 1'b0;
      txOverrun  <= 1'b0;
      rxUnderrun <= 1'b0;
    end else begin
      if (wrCtrl) begin
        txHold  <= hostWdata[CTRL_TXHOLD];
        rxHold  <= hostWdata[CTRL_RXHOLD];
        txIrqEn <= hostWdata[CTRL_TXIEN];
        rxIrqEn <= hostWdata[CTRL_RXIEN];
      end
      if (wrLevel) begin
        txLevel <= hostWdata[LVL_TX_LSB +: LVL_W];
        rxLevel <= hostWdata[LVL_RX_LSB +: LVL_W];
      end
      txReqFlag  <= (txReqFlag && keepTxReq) || txSet;
      rxReqFlag  <= (rxReqFlag && keepRxReq) || rxSet;
      txOverrun  <= (txOverrun && keepOvr) || ovrSet;
      rxUnderrun <= (rxUnderrun && keepUnd) || undSet;
    end
  end

  assign txReqIrq = txReqFlag && txIrqEn;
  assign rxReqIrq = rxReqFlag && rxIrqEn;

  always_comb begin
    view            = '0;
    view.txHold     = txHold;
    view.rxHold     = rxHold;
    view.txReqFlag  = txReqFlag;
    view.rxReqFlag  = rxReqFlag;
    view.txOverrun  = txOverrun;
    view.rxUnderrun = rxUnderrun;
  end

  // Host read mux
  always_comb begin
    hostRdata = '0;
    unique case (sel)
      REG_CTRL: begin
        hostRdata[CTRL_TXHOLD] = txHold;
        hostRdata[CTRL_RXHOLD] = rxHold;
        hostRdata[CTRL_TXIEN]  = txIrqEn;
        hostRdata[CTRL_RXIEN]  = rxIrqEn;
      end
      REG_STAT: begin
        hostRdata[STAT_TXCNT_LSB +: CNT_W] = txCount;
        hostRdata[STAT_RXCNT_LSB +: CNT_W] = rxCount;
        hostRdata[STAT_TXREQ] = txReqFlag;
        hostRdata[STAT_RXREQ] = rxReqFlag;
        hostRdata[STAT_TXOVR] = txOverrun;
        hostRdata[STAT_RXUND] = rxUnderrun;
      end
      REG_LEVEL: begin
        hostRdata[LVL_TX_LSB +: LVL_W] = txLevel;
        hostRdata[LVL_RX_LSB +: LVL_W] = rxLevel;
      end
      REG_DATA: begin
        if (!rxEmpty) hostRdata[WORD_W-1 -: SAMPLE_W] = rxHead;
      end
      default: hostRdata = '0;
    endcase
  end

endmodule

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo
  import asf_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int SAMPLE_W = 16,
  parameter int WORD_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          hostAddr,
  input  logic                hostWr,
  input  logic                hostRd,
  input  logic [WORD_W-1:0]   hostWdata,
  output logic [WORD_W-1:0]   hostRdata,
  input  logic                txTake,
  output logic [SAMPLE_W-1:0] txSample,
  output logic                txAvail,
  input  logic                rxPut,
  input  logic [SAMPLE_W-1:0] rxSample,
  output logic                txReqIrq,
  output logic                rxReqIrq
);

  localparam int LVL_W = $clog2(DEPTH);
  localparam int CNT_W = LVL_W + 1;

  qStrobe_t            strobe;
  ctrlView_t           ctrlView;
  logic [CNT_W-1:0]    txCount;
  logic [CNT_W-1:0]    rxCount;
  logic [LVL_W-1:0]    txLevel;
  logic [LVL_W-1:0]    rxLevel;
  logic [SAMPLE_W-1:0] rxHead;

  asf_ctrl #(.DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .hostAddr  (hostAddr),
    .hostWr    (hostWr),
    .hostRd    (hostRd),
    .hostWdata (hostWdata),
    .hostRdata (hostRdata),
    .txTake    (txTake),
    .rxPut     (rxPut),
    .txCount   (txCount),
    .rxCount   (rxCount),
    .rxHead    (rxHead),
    .strobe    (strobe),
    .txReqIrq  (txReqIrq),
    .rxReqIrq  (rxReqIrq),
    .view      (ctrlView),
    .txLevel   (txLevel),
    .rxLevel   (rxLevel)
  );

  asf_datapath #(.DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W)) datapath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .txPushData (hostWdata[WORD_W-1 -: SAMPLE_W]),
    .rxPushData (rxSample),
    .txHead     (txSample),
    .rxHead     (rxHead),
    .txCount    (txCount),
    .rxCount    (rxCount)
  );

  assign txAvail = (txCount != '0);

endmodule

// File: rtl/asf_checker.sv
module asf_checker
  import asf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CNT_W = 6,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             hostWr,
  input logic             hostRd,
  input logic [1:0]       hostAddr,
  input logic [CNT_W-1:0] txCount,
  input logic [CNT_W-1:0] rxCount,
  input logic [LVL_W-1:0] txLevel,
  input logic [LVL_W-1:0] rxLevel,
  input ctrlView_t        view
);

  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

  logic ctrlWrite;
  assign ctrlWrite = hostWr && (hostAddr == REG_CTRL);

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txCount <= FULL_C) && (rxCount <= FULL_C));

  // R7
  tx_hold_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    view.txHold |=> (txCount == '0));

  // R7
  rx_hold_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    view.rxHold |=> (rxCount == '0));

  // R8
  tx_overrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr == REG_DATA && txCount == FULL_C && !view.txHold)
      |=> view.txOverrun);

  // R9
  rx_underrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && !hostWr && hostAddr == REG_DATA && rxCount == '0)
      |=> view.rxUnderrun);

  // R4
  tx_req_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!view.txHold && txCount <= {1'b0, txLevel} && !ctrlWrite)
      |=> view.txReqFlag);

  // R5
  rx_req_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!view.rxHold && rxCount > {1'b0, rxLevel} && !ctrlWrite)
      |=> view.rxReqFlag);

endmodule

bind audio_sample_fifo asf_checker #(
  .DEPTH (DEPTH),
  .CNT_W (CNT_W),
  .LVL_W (LVL_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .hostWr   (hostWr),
  .hostRd   (hostRd),
  .hostAddr (hostAddr),
  .txCount  (txCount),
  .rxCount  (rxCount),
  .txLevel  (txLevel),
  .rxLevel  (rxLevel),
  .view     (ctrlView)
);

// File: tb/audio_sample_fifo_tb_top.sv
module audio_sample_fifo_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_LVL = 2'd2, A_DATA = 2'd3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  hostAddr = '0;
  logic        hostWr = 1'b0;
  logic        hostRd = 1'b0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        txTake = 1'b0;
  logic [15:0] txSample;
  logic        txAvail;
  logic        rxPut = 1'b0;
  logic [15:0] rxSample = '0;
  logic        txReqIrq;
  logic        rxReqIrq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  audio_sample_fifo dut_i (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .txTake(txTake), .txSample(txSample),
    .txAvail(txAvail), .rxPut(rxPut), .rxSample(rxSample), .txReqIrq(txReqIrq),
    .rxReqIrq(rxReqIrq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    hostAddr = a; hostWdata = d; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    hostAddr = a; hostRd = 1'b1;
    #1 d = hostRdata;
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic serTake(output logic [15:0] s);
    @(negedge clk);
    s = txSample; txTake = 1'b1;
    @(negedge clk);
    txTake = 1'b0;
  endtask

  task automatic serPut(input logic [15:0] s);
    @(negedge clk);
    rxSample = s; rxPut = 1'b1;
    @(negedge clk);
    rxPut = 1'b0;
  endtask

  task automatic testReset;
    logic [31:0] d;
    hostRead(A_CTRL, d); check("R11 ctrl after reset", d, 32'h3);
    hostRead(A_LVL, d);  check("R11 levels after reset", d, 32'h0000_000F);
    hostRead(A_STAT, d); check("R11 status after reset", d, 32'h0);
    check("R11 irqs/txAvail after reset", {29'h0, txReqIrq, rxReqIrq, txAvail}, 32'h0);
  endtask

  task automatic testTxThreshold;
    logic [31:0] d;
    logic [15:0] s;
    hostWrite(A_CTRL, 32'hC);
    idle(2);
    hostRead(A_STAT, d); check("R4 tx flag on empty released queue", d, 32'h0001_0000);
    check("R6 tx irq enabled", {31'h0, txReqIrq}, 32'h1);
    check("R6 rx irq idle", {31'h0, rxReqIrq}, 32'h0);
    for (int i = 0; i < 20; i++) hostWrite(A_DATA, {16'hA000 + 16'(i), 16'h5555});
    hostWrite(A_STAT, 32'h0);
    idle(2);
    hostRead(A_STAT, d); check("R1 R4 count 20 flag cleared", d, 32'h1400_0000);
    check("R2 txAvail with data", {31'h0, txAvail}, 32'h1);
    for (int i = 0; i < 5; i++) begin
      serTake(s); check("R2 tx order", {16'h0, s}, {16'h0, 16'hA000 + 16'(i)});
    end
    idle(2);
    hostRead(A_STAT, d); check("R4 tx flag at level", d, 32'h0F01_0000);
    for (int i = 5; i < 20; i++) begin
      serTake(s); check("R2 tx order", {16'h0, s}, {16'h0, 16'hA000 + 16'(i)});
    end
    idle(1);
    check("R2 txAvail after drain", {31'h0, txAvail}, 32'h0);
  endtask

  task automatic testTxOverrun;
    logic [31:0] d;
    logic [15:0] s;
    for (int i = 0; i < 33; i++) hostWrite(A_DATA, {16'hB000 + 16'(i), 16'h0});
    idle(2);
    hostRead(A_STAT, d); check("R8 R1 full count and overrun", d & 32'h3F10_0000, 32'h2010_0000);
    hostWrite(A_STAT, 32'h0010_0000);
    idle(2);
    hostRead(A_STAT, d); check("R8 writing 1 keeps overrun", d, 32'h2010_0000);
    hostWrite(A_STAT, 32'h0);
    idle(2);
    hostRead(A_STAT, d); check("R8 overrun cleared", d, 32'h2000_0000);
    for (int i = 0; i < 32; i++) begin
      serTake(s); check("R8 R2 drain after overrun", {16'h0, s}, {16'h0, 16'hB000 + 16'(i)});
    end
    idle(1);
    check("R8 extra sample dropped", {31'h0, txAvail}, 32'h0);
    hostWrite(A_STAT, 32'h0);
  endtask

  task automatic testRxThreshold;
    logic [31:0] d;
    hostWrite(A_LVL, 32'h0000_030F);
    hostRead(A_LVL, d); check("R5 level readback", d, 32'h0000_030F);
    for (int i = 0; i < 3; i++) serPut(16'hC000 + 16'(i));
    idle(2);
    hostRead(A_STAT, d); check("R5 count equal level no flag", d & 32'h0000_3F01, 32'h0000_0300);
    check("R6 rx irq low", {31'h0, rxReqIrq}, 32'h0);
    serPut(16'hC003);
    idle(2);
    hostRead(A_STAT, d); check("R5 count above level flag", d & 32'h0000_3F01, 32'h0000_0401);
    check("R6 rx irq high", {31'h0, rxReqIrq}, 32'h1);
    for (int i = 0; i < 4; i++) begin
      hostRead(A_DATA, d); check("R3 rx read order", d, {16'hC000 + 16'(i), 16'h0});
    end
    idle(2);
    hostWrite(A_STAT, 32'h0);
    idle(2);
    hostRead(A_STAT, d); check("R5 rx flag cleared", d & 32'h0000_3F11, 32'h0);
  endtask

  task automatic testUnderrun;
    logic [31:0] d;
    hostRead(A_DATA, d); check("R9 empty read returns 0", d, 32'h0);
    idle(1);
    hostRead(A_STAT, d); check("R9 underrun set", d & 32'h10, 32'h10);
    hostWrite(A_STAT, 32'h0);
    idle(1);
    hostRead(A_STAT, d); check("R9 underrun cleared", d & 32'h10, 32'h0);
  endtask

  task automatic testHold;
    logic [31:0] d;
    hostWrite(A_CTRL, 32'hF);
    hostWrite(A_DATA, 32'hDEAD_0000);
    hostWrite(A_DATA, 32'hBEEF_0000);
    serPut(16'h1234);
    serPut(16'h5678);
    idle(2);
    hostWrite(A_STAT, 32'h0);
    idle(2);
    hostRead(A_STAT, d); check("R7 held queues empty no flags", d, 32'h0);
    check("R7 txAvail while held", {31'h0, txAvail}, 32'h0);
    check("R7 irqs while held", {30'h0, txReqIrq, rxReqIrq}, 32'h0);
    hostWrite(A_CTRL, 32'hC);
    idle(2);
    hostRead(A_STAT, d); check("R7 pushes ignored after release", d, 32'h0001_0000);
  endtask

  task automatic testSoftReset;
    logic [31:0] d;
    hostWrite(A_LVL, 32'h0000_050A);
    for (int i = 0; i < 3; i++) hostWrite(A_DATA, {16'hE000 + 16'(i), 16'h0});
    hostWrite(A_CTRL, 32'h0000_010C);
    idle(2);
    hostRead(A_CTRL, d); check("R10 ctrl after port reset", d, 32'h3);
    hostRead(A_LVL, d);  check("R10 levels after port reset", d, 32'h0000_000F);
    hostRead(A_STAT, d); check("R10 status after port reset", d, 32'h0);
    check("R10 txAvail after port reset", {31'h0, txAvail}, 32'h0);
    hostWrite(A_CTRL, 32'h0);
    serPut(16'hD00D);
    idle(2);
    hostRead(A_STAT, d); check("R5 level 0 fires on one sample", d & 32'h0000_3F01, 32'h0000_0101);
    check("R6 rx irq disabled", {31'h0, rxReqIrq}, 32'h0);
    hostRead(A_DATA, d); check("R3 single sample read", d, 32'hD00D_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle(1);
    testReset();
    testTxThreshold();
    testTxOverrun();
    testRxThreshold();
    testUnderrun();
    testHold();
    testSoftReset();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule